// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block guards a software-initiated change of a clock generator's operating frequency. Software arms the guard and then requests a new frequency. Each accepted request reloads a 5-bit countdown. The countdown steps once per time unit, and a one-bit unit select picks a short unit or a long unit. If software does not disarm the guard before the count runs out, the block raises a sticky timeout flag. It then enters a recovery mode that forces a stored recovery setting onto the frequency logic and refuses any further frequency requests. The block leaves this mode only when software clears the arm bit.

Both units are counted in cycles of a base time tick. The tick is an input so that a system can feed a slow time base and a bench can feed a fast one. A reset request is driven active low as an open-drain enable, and it lasts a parameterised number of base ticks. Two separate enables cause it to fire: one on a timeout, the other on every accepted frequency request. When the count runs out, the block captures the recovery source choice and the recovery N and M values. The source choice is either the latched strap index or the N/M pair.

Top module: `freq_guard_wdt`

## Requirements
- R1: While `rst` is high and after it falls, `rst_pin_n`=1, `tmo_status`=0, `rcv_active`=0, `wr_lock`=0, `rcv_use_nm`=0, `rcv_n`=0 and `rcv_m`=0.
- R2: With `wd_en`=1, an accepted `fc_req` restarts the count. `tmo_status` becomes 1 after the edge that ends max(`tmo_value`,1) units. A unit is SHORT_TICKS base ticks when `unit_sel`=0 and LONG_TICKS base ticks when `unit_sel`=1. With a tick every cycle, the flag is 1 from the negedge after edge e0+units*len, where e0 is the edge that accepts the request.
- R3: Setting `wd_en` does not by itself start the count. Without an accepted `fc_req`, no timeout occurs.
- R4: Clearing `wd_en` stops the count and reloads it. After re-arming, a new request counts the full period again.
- R5: `tmo_status` is sticky. A cycle with `sts_wr`=1 and `sts_wdata`=1 clears it at the next edge. A cycle with `sts_wr`=1 and `sts_wdata`=0 leaves it unchanged. When a timeout and a clear fall in the same cycle, the timeout wins.
- R6: A timeout drives `rst_pin_n` low only when `rst_on_tmo_en`=1. The pin goes low from the timeout edge and stays low for RST_TICKS base ticks.
- R7: An accepted `fc_req` with `rst_on_chg_en`=1 drives `rst_pin_n` low for RST_TICKS base ticks, starting at the accepting edge. This holds whether or not `wd_en` is set.
- R8: A timeout sets `rcv_active` and `wr_lock`. It also captures `rcv_src_nm`, `rcv_n_in` and `rcv_m_in` onto `rcv_use_nm`, `rcv_n` and `rcv_m`, and these outputs hold against later input changes. `rcv_active` and `wr_lock` stay set until the edge after `wd_en` is seen at 0.
- R9: While `wr_lock`=1, `fc_req` is ignored. It produces no reset pulse, it does not restart the count, and so no new timeout follows.
- R10: The count advances only on cycles where `base_tick`=1. With a tick on every other cycle, a period of 3 ticks has not ended 4 edges after the accepting edge and has ended 6 edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_tick | input | 1 | Time-base tick, one cycle wide |
| tmo_value | input | 5 | Timeout count in units |
| unit_sel | input | 1 | 0 = short unit, 1 = long unit |
| wd_en | input | 1 | Arm bit; 0 stops, reloads and unlocks |
| rst_on_tmo_en | input | 1 | Reset pulse on timeout enable |
| rst_on_chg_en | input | 1 | Reset pulse on frequency change enable |
| rcv_src_nm | input | 1 | Recovery source: 0 strap index, 1 N/M pair |
| rcv_n_in | input | 8 | Recovery N value |
| rcv_m_in | input | 7 | Recovery M value |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 1 | Status write data; 1 clears |
| fc_req | input | 1 | Frequency change request, one cycle |
| rst_pin_n | output | 1 | Open-drain reset enable, 0 = pull low |
| tmo_status | output | 1 | Sticky timeout flag |
| rcv_active | output | 1 | Recovery setting in force |
| wr_lock | output | 1 | Frequency writes refused |
| rcv_use_nm | output | 1 | Captured recovery source |
| rcv_n | output | 8 | Captured recovery N |
| rcv_m | output | 7 | Captured recovery M |

## Verification
A wrong prescale or count state moves the edge where `tmo_status` rises by at least one base tick. Each timed case therefore samples the flag one cycle before and at the expected edge. A lock that fails to set or release shows in the first following `fc_req`, because a reset pulse appears or is missing on the next cycle and a timeout appears or is missing one period later. A wrong pulse counter moves the rising edge of `rst_pin_n`, and the bench checks that edge on both sides.

// File: rtl/fgw_pkg.sv
package fgw_pkg;

    localparam int TMO_W = 5;
    localparam int N_W   = 8;
    localparam int M_W   = 7;

    // Recovery setting captured at timeout
    typedef struct packed {
        logic           use_nm;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } rcv_set_t;

    localparam rcv_set_t RCV_RESET = '{use_nm: 1'b0, n: '0, m: '0};

endpackage

// File: rtl/fgw_unit_div.sv
module fgw_unit_div #(
    parameter int SHORT_TICKS = 3,
    parameter int LONG_TICKS  = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    input  logic unit_sel,
    output logic unit_tick
);
    localparam int PW = $clog2(LONG_TICKS + 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] last_v;

    assign last_v    = unit_sel ? PW'(LONG_TICKS - 1) : PW'(SHORT_TICKS - 1);
    assign unit_tick = tick && (pre_q >= last_v);

    always_ff @(posedge clk) begin
        if (rst || clear)
            pre_q <= '0;
        else if (tick)
            pre_q <= (pre_q >= last_v) ? '0 : pre_q + 1'b1;
    end

    // R10
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(pre_q));

endmodule

// File: rtl/fgw_countdown.sv
module fgw_countdown #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         start,
    input  logic         unit_tick,
    input  logic [W-1:0] load_val,
    output logic         running,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic         run_q;

    // A value of 0 or 1 both end after one unit
    assign expire  = enable && run_q && unit_tick && (cnt_q <= W'(1));
    assign running = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!enable) begin
            run_q <= 1'b0;
            cnt_q <= load_val;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= load_val;
        end else if (expire) begin
            run_q <= 1'b0;
        end else if (run_q && unit_tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R4
    disarm_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !running);

    // R3
    start_needed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(start));

endmodule

// File: rtl/fgw_rst_pulse.sv
module fgw_rst_pulse #(
    parameter int RST_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    input  logic tick,
    output logic pin_n
);
    localparam int CW = $clog2(RST_TICKS + 1);

    logic [CW-1:0] left_q;

    assign pin_n = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (trigger)
            left_q <= CW'(RST_TICKS);
        else if (tick && left_q != '0)
            left_q <= left_q - 1'b1;
    end

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_n) |-> $past(trigger));

endmodule

// File: rtl/freq_guard_wdt.sv
module freq_guard_wdt
    import fgw_pkg::*;
#(
    parameter int SHORT_TICKS = 3,
    parameter int LONG_TICKS  = 50,
    parameter int RST_TICKS   = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           base_tick,
    input  logic [TMO_W-1:0] tmo_value,
    input  logic           unit_sel,
    input  logic           wd_en,
    input  logic           rst_on_tmo_en,
    input  logic           rst_on_chg_en,
    input  logic           rcv_src_nm,
    input  logic [N_W-1:0] rcv_n_in,
    input  logic [M_W-1:0] rcv_m_in,
    input  logic           sts_wr,
    input  logic           sts_wdata,
    input  logic           fc_req,
    output logic           rst_pin_n,
    output logic           tmo_status,
    output logic           rcv_active,
    output logic           wr_lock,
    output logic           rcv_use_nm,
    output logic [N_W-1:0] rcv_n,
    output logic [M_W-1:0] rcv_m
);
    logic     cd_running;
    logic     cd_expire;
    logic     unit_tick;
    logic     fc_ok;
    logic     pulse_trig;
    logic     lock_q;
    logic     status_q;
    rcv_set_t rcv_q;

    // A request in the expiry cycle is dropped: recovery takes effect first
    assign fc_ok      = fc_req && !lock_q && !cd_expire;
    assign pulse_trig = (cd_expire && rst_on_tmo_en) || (fc_ok && rst_on_chg_en);

    fgw_unit_div #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) i_div (
        .clk       (clk),
        .rst       (rst),
        .clear     (!cd_running || fc_ok),
        .tick      (base_tick),
        .unit_sel  (unit_sel),
        .unit_tick (unit_tick)
    );

    fgw_countdown #(.W(TMO_W)) i_cd (
        .clk       (clk),
        .rst       (rst),
        .enable    (wd_en),
        .start     (fc_ok),
        .unit_tick (unit_tick),
        .load_val  (tmo_value),
        .running   (cd_running),
        .expire    (cd_expire)
    );

    fgw_rst_pulse #(.RST_TICKS(RST_TICKS)) i_pulse (
        .clk     (clk),
        .rst     (rst),
        .trigger (pulse_trig),
        .tick    (base_tick),
        .pin_n   (rst_pin_n)
    );

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= 1'b0;
        else if (cd_expire)
            status_q <= 1'b1;
        else if (sts_wr && sts_wdata)
            status_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            rcv_q  <= RCV_RESET;
        end else if (!wd_en) begin
            lock_q <= 1'b0;
        end else if (cd_expire) begin
            lock_q <= 1'b1;
            rcv_q  <= '{use_nm: rcv_src_nm, n: rcv_n_in, m: rcv_m_in};
        end
    end

    assign tmo_status = status_q;
    assign rcv_active = lock_q;
    assign wr_lock    = lock_q;
    assign rcv_use_nm = rcv_q.use_nm;
    assign rcv_n      = rcv_q.n;
    assign rcv_m      = rcv_q.m;

    // R2
    status_armed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_status) |-> $past(wd_en));

    // R5
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tmo_status && !(sts_wr && sts_wdata)) |=> tmo_status);

    // R8
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> !rcv_active);

    // R8
    lock_enter_chk: assert property (@(posedge clk) disable iff (rst)
        cd_expire |=> (rcv_active && tmo_status));

    // R9
    locked_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rcv_active |-> !cd_running);

endmodule

// File: tb/test_freq_guard_wdt.sv
module test_freq_guard_wdt;
    localparam int SHORT_TICKS = 3;
    localparam int LONG_TICKS  = 50;
    localparam int RST_TICKS   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic base_tick = 1'b1;
    logic half_rate = 1'b0;
    logic [4:0] tmo_value = 5'd0;
    logic unit_sel = 1'b0, wd_en = 1'b0, rst_on_tmo_en = 1'b0, rst_on_chg_en = 1'b0;
    logic rcv_src_nm = 1'b0;
    logic [7:0] rcv_n_in = 8'd0;
    logic [6:0] rcv_m_in = 7'd0;
    logic sts_wr = 1'b0, sts_wdata = 1'b0, fc_req = 1'b0;
    logic rst_pin_n, tmo_status, rcv_active, wr_lock, rcv_use_nm;
    logic [7:0] rcv_n;
    logic [6:0] rcv_m;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(negedge clk) base_tick <= half_rate ? ~base_tick : 1'b1;

    freq_guard_wdt #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS),
                     .RST_TICKS(RST_TICKS)) i_freq_guard_wdt (
        .clk(clk), .rst(rst), .base_tick(base_tick), .tmo_value(tmo_value),
        .unit_sel(unit_sel), .wd_en(wd_en), .rst_on_tmo_en(rst_on_tmo_en),
        .rst_on_chg_en(rst_on_chg_en), .rcv_src_nm(rcv_src_nm),
        .rcv_n_in(rcv_n_in), .rcv_m_in(rcv_m_in), .sts_wr(sts_wr),
        .sts_wdata(sts_wdata), .fc_req(fc_req), .rst_pin_n(rst_pin_n),
        .tmo_status(tmo_status), .rcv_active(rcv_active), .wr_lock(wr_lock),
        .rcv_use_nm(rcv_use_nm), .rcv_n(rcv_n), .rcv_m(rcv_m)
    );

    // {unit_sel, tmo_value, expected edges after accept}
    typedef struct packed { logic u; logic [4:0] v; logic [15:0] exp; } vec_t;
    localparam vec_t VECS [6] = '{
        '{u: 1'b0, v: 5'd2,  exp: 16'd6},
        '{u: 1'b0, v: 5'd0,  exp: 16'd3},
        '{u: 1'b0, v: 5'd1,  exp: 16'd3},
        '{u: 1'b1, v: 5'd1,  exp: 16'd50},
        '{u: 1'b0, v: 5'd31, exp: 16'd93},
        '{u: 1'b1, v: 5'd3,  exp: 16'd150}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic freq_change();
        fc_req = 1'b1;
        @(negedge clk);
        fc_req = 1'b0;
    endtask

    task automatic clear_status(input logic d);
        sts_wr = 1'b1; sts_wdata = d;
        @(negedge clk);
        sts_wr = 1'b0; sts_wdata = 1'b0;
    endtask

    task automatic disarm();
        wd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1 during and after reset
        check("R1 pin", rst_pin_n, 1);
        check("R1 status", tmo_status, 0);
        rst = 1'b0;
        step(1);
        check("R1 active", rcv_active, 0);
        check("R1 lock", wr_lock, 0);
        check("R1 rcv", {rcv_use_nm, rcv_n, rcv_m}, 0);

        // R2 timing table, R6 no pulse when disabled
        foreach (VECS[i]) begin
            disarm();
            clear_status(1'b1);
            tmo_value = VECS[i].v; unit_sel = VECS[i].u; wd_en = 1'b1;
            freq_change();
            step(int'(VECS[i].exp) - 1);
            check("R2 before", tmo_status, 0);
            step(1);
            check("R2 at", tmo_status, 1);
            check("R8 active", rcv_active, 1);
            check("R6 no pulse", rst_pin_n, 1);
        end

        // R5 write 0 keeps, write 1 clears
        clear_status(1'b0);
        check("R5 w0", tmo_status, 1);
        clear_status(1'b1);
        check("R5 w1", tmo_status, 0);

        // R9 locked: request ignored
        rst_on_chg_en = 1'b1;
        tmo_value = 5'd1; unit_sel = 1'b0;
        freq_change();
        check("R9 no pulse", rst_pin_n, 1);
        step(10);
        check("R9 no timeout", tmo_status, 0);
        check("R9 lock", wr_lock, 1);

        // R8 release, R7 pulse with wd_en=0
        disarm();
        check("R8 release", wr_lock, 0);
        freq_change();
        check("R7 low", rst_pin_n, 0);
        step(RST_TICKS - 1);
        check("R7 still low", rst_pin_n, 0);
        step(1);
        check("R7 high", rst_pin_n, 1);
        rst_on_chg_en = 1'b0;

        // R3 arming alone does nothing
        wd_en = 1'b1;
        step(20);
        check("R3 idle", tmo_status, 0);

        // R4 stop and reload
        tmo_value = 5'd2;
        freq_change();
        step(3);
        disarm();
        wd_en = 1'b1;
        step(10);
        check("R4 stopped", tmo_status, 0);
        freq_change();
        step(5);
        check("R4 full before", tmo_status, 0);
        step(1);
        check("R4 full at", tmo_status, 1);

        // R6 pulse on timeout, R8 capture
        disarm();
        clear_status(1'b1);
        rst_on_tmo_en = 1'b1; rcv_src_nm = 1'b1; rcv_n_in = 8'hA5; rcv_m_in = 7'h2D;
        tmo_value = 5'd1; wd_en = 1'b1;
        freq_change();
        step(2);
        check("R6 pin before", rst_pin_n, 1);
        step(1);
        check("R6 status", tmo_status, 1);
        check("R6 low", rst_pin_n, 0);
        rcv_src_nm = 1'b0; rcv_n_in = 8'h00; rcv_m_in = 7'h00;
        step(RST_TICKS - 1);
        check("R6 still low", rst_pin_n, 0);
        step(1);
        check("R6 high", rst_pin_n, 1);
        check("R8 capture", {rcv_use_nm, rcv_n, rcv_m}, {1'b1, 8'hA5, 7'h2D});
        rst_on_tmo_en = 1'b0;

        // R10 tick every other cycle, 3-tick period
        disarm();
        clear_status(1'b1);
        half_rate = 1'b1;
        tmo_value = 5'd1; wd_en = 1'b1;
        freq_change();
        step(4);
        check("R10 before", tmo_status, 0);
        step(2);
        check("R10 after", tmo_status, 1);
        half_rate = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule